// File: doc/BRIEF.md
# Fault-Mode Two-Axis Space-Vector Modulator

This block drives a power converter that is running with one phase leg out of service. It commands the upper switches of the two phase legs that still work and of a backup leg tied to the grid neutral. The lower switch of each leg is always the complement of its upper switch. Every modulation period of `PERIOD` clock cycles, the block samples a signed reference voltage pair. The real part is the voltage across the first surviving leg and the imaginary part is the voltage across the second, both scaled to the dc-bus voltage. From that pair the block picks one of six sectors, works out how long each vector is applied, and plays the vectors out in a fixed order.

The switch state of the three legs produces eight vectors: two null vectors, four of magnitude E and two of magnitude √2·E. These form six sectors of unequal width. Each sector has its own pair of dwell-time expressions. The time left in the period after the two active vectors is shared between the two null vectors according to a programmable fraction. If the reference asks for more active time than the period holds, the two active times are scaled back to fill exactly one period and an overmodulation flag is raised for that period.

Top module: `svm_fault_mod`

## Requirements
- R1: While `rst_n` is low, `sw_hi` is 000, `sw_lo` is 111 and `ovm` is 0.
- R2: A clock edge that samples `en` low sets `sw_hi` to 000 and clears `ovm`. The next edge that samples `en` high begins a new period and samples fresh inputs.
- R3: `sw_lo` is the bitwise complement of `sw_hi` at all times. Bit 2 is the first surviving leg, bit 1 is the second surviving leg and bit 0 is the neutral leg. A 1 means the switch is closed.
- R4: Let x be `ref_re` and y be `ref_im`. The sector is chosen as follows. Sector 1 when x>0, y≥0 and x>y. Sector 2 when x>0, y≥0 and x≤y. Sector 3 when x≤0 and y>0. Sector 4 when x<0, y≤0 and x<y. Sector 5 when x<0, y<0 and x≥y. Sector 6 when x≥0 and y<0. The origin (0,0) uses sector 1.
- R5: The vector codes are written as `sw_hi` bits {2,1,0}: v0=000, v1=100, v2=110, v3=010, v4=011, v5=001, v6=101, v7=111. In sector K, a period plays v0, then vK, then the next vector, then v7. The vector after v6 is v1.
- R6: The raw magnitudes (a, b) for the first and second active vector are: sector 1 (x−y, y), sector 2 (x, y−x), sector 3 (y, −x), sector 4 (y−x, −y), sector 5 (−x, x−y), sector 6 (−y, x). Without overmodulation, the active times in cycles are floor(a·PERIOD/2^FRAC_W) and floor(b·PERIOD/2^FRAC_W).
- R7: Let n be PERIOD minus both active times. The first null time is floor(n·lam/2^LAM_W) and the closing null time takes the rest of n.
- R8: When a+b > 2^FRAC_W, the first active time is floor(a·PERIOD/(a+b)), the second is PERIOD minus the first, both null times are zero, and `ovm` is 1 for the whole of that period.
- R9: `ref_re`, `ref_im` and `lam` are sampled only at the edge that starts a period. Changes at other times have no effect until the next period.
- R10: A period lasts exactly PERIOD clock cycles. The first vector of a period appears at the outputs right after the edge that sampled the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Modulator enable; low forces the v0 state |
| ref_re | input | REF_W | Signed reference, first surviving leg, FRAC_W fraction bits of dc-bus voltage |
| ref_im | input | REF_W | Signed reference, second surviving leg, same scaling |
| lam | input | LAM_W | Null-time split fraction, lam/2^LAM_W |
| sw_hi | output | 3 | Upper switch commands {leg A, leg B, neutral} |
| sw_lo | output | 3 | Lower switch commands, complement of sw_hi |
| ovm | output | 1 | Overmodulation flag for the current period |

## Verification
The bench applies one interior reference in each of the six sectors. This shows that every sector has its own pair of vectors and its own dwell expressions. It then drives points that lie on the sector borders and at the origin, which is where the tie-breaking comparisons decide between neighbouring sectors. The split fraction is swept from zero to near full scale, which separates the first null slot from the closing one. Two kinds of reference test the scaled path: a pair whose sum lies just inside the period, and pairs far outside it. The bench also changes the reference in the middle of a period and drops the enable in the middle of a period. These cases show that the inputs are taken only at the period boundary and that a restart begins a clean period.

// File: rtl/svm_fault_pkg.sv
package svm_fault_pkg;

    typedef logic [2:0] sector_t;
    typedef logic [2:0] vidx_t;
    typedef logic [2:0] legs_t;

    // Switch pattern {leg A, leg B, neutral leg} for each vector index.
    function automatic legs_t vec_bits(input vidx_t idx);
        legs_t b;
        case (idx)
            3'd0:    b = 3'b000;
            3'd1:    b = 3'b100;
            3'd2:    b = 3'b110;
            3'd3:    b = 3'b010;
            3'd4:    b = 3'b011;
            3'd5:    b = 3'b001;
            3'd6:    b = 3'b101;
            default: b = 3'b111;
        endcase
        return b;
    endfunction

    // Active vector that follows vector k, with v6 wrapping to v1.
    function automatic vidx_t next_active(input sector_t k);
        return (k == 3'd6) ? 3'd1 : vidx_t'(k + 3'd1);
    endfunction

endpackage

// File: rtl/svm_sector_dec.sv
module svm_sector_dec
    import svm_fault_pkg::*;
#(
    parameter int REF_W = 12
) (
    input  logic signed [REF_W-1:0] re_i,
    input  logic signed [REF_W-1:0] im_i,
    output sector_t                 sec_o,
    output logic [REF_W:0]          mag_a_o,
    output logic [REF_W:0]          mag_b_o
);

    localparam int EXT_W = REF_W + 1;

    logic signed [EXT_W-1:0] x, y, x_m_y, y_m_x, neg_x, neg_y;

    assign x     = {re_i[REF_W-1], re_i};
    assign y     = {im_i[REF_W-1], im_i};
    assign x_m_y = x - y;
    assign y_m_x = y - x;
    assign neg_x = -x;
    assign neg_y = -y;

    always_comb begin
        if (x > 0 && y >= 0)       sec_o = (x > y) ? 3'd1 : 3'd2;
        else if (x <= 0 && y > 0)  sec_o = 3'd3;
        else if (x < 0 && y <= 0)  sec_o = (x < y) ? 3'd4 : 3'd5;
        else if (x >= 0 && y < 0)  sec_o = 3'd6;
        else                       sec_o = 3'd1;   // origin
    end

    always_comb begin
        case (sec_o)
            3'd1:    begin mag_a_o = $unsigned(x_m_y); mag_b_o = $unsigned(y);     end
            3'd2:    begin mag_a_o = $unsigned(x);     mag_b_o = $unsigned(y_m_x); end
            3'd3:    begin mag_a_o = $unsigned(y);     mag_b_o = $unsigned(neg_x); end
            3'd4:    begin mag_a_o = $unsigned(y_m_x); mag_b_o = $unsigned(neg_y); end
            3'd5:    begin mag_a_o = $unsigned(neg_x); mag_b_o = $unsigned(x_m_y); end
            default: begin mag_a_o = $unsigned(neg_y); mag_b_o = $unsigned(x);     end
        endcase
    end

endmodule

// File: rtl/svm_dwell_calc.sv
module svm_dwell_calc #(
    parameter int REF_W  = 12,
    parameter int FRAC_W = 10,
    parameter int LAM_W  = 8,
    parameter int PERIOD = 100,
    parameter int CNT_W  = 7
) (
    input  logic [REF_W:0]   mag_a_i,
    input  logic [REF_W:0]   mag_b_i,
    input  logic [LAM_W-1:0] lam_i,
    output logic [CNT_W-1:0] ta_o,
    output logic [CNT_W-1:0] tb_o,
    output logic [CNT_W-1:0] t0_o,
    output logic [CNT_W-1:0] t7_o,
    output logic             ovm_o
);

    localparam int SUM_W  = REF_W + 2;
    localparam int PROD_W = SUM_W + CNT_W;
    localparam int NP_W   = CNT_W + LAM_W;
    localparam logic [SUM_W-1:0]  FULL  = SUM_W'(2 ** FRAC_W);
    localparam logic [PROD_W-1:0] PER_P = PROD_W'(PERIOD);
    localparam logic [CNT_W-1:0]  PER_C = CNT_W'(PERIOD);

    logic [SUM_W-1:0]  sum_ab;
    logic [PROD_W-1:0] prod_a, prod_b, divisor, quot_a;
    logic [CNT_W-1:0]  nul;
    logic [NP_W-1:0]   nprod;

    always_comb begin
        sum_ab  = SUM_W'(mag_a_i) + SUM_W'(mag_b_i);
        ovm_o   = (sum_ab > FULL);
        prod_a  = PROD_W'(mag_a_i) * PER_P;
        prod_b  = PROD_W'(mag_b_i) * PER_P;
        divisor = ovm_o ? PROD_W'(sum_ab) : PROD_W'(1);
        quot_a  = prod_a / divisor;
        if (ovm_o) begin
            ta_o = CNT_W'(quot_a);
            tb_o = PER_C - CNT_W'(quot_a);
        end else begin
            ta_o = CNT_W'(prod_a >> FRAC_W);
            tb_o = CNT_W'(prod_b >> FRAC_W);
        end
        nul   = PER_C - ta_o - tb_o;
        nprod = NP_W'(nul) * NP_W'(lam_i);
        t0_o  = CNT_W'(nprod >> LAM_W);
        t7_o  = nul - t0_o;
    end

endmodule

// File: rtl/svm_fault_mod.sv
module svm_fault_mod
    import svm_fault_pkg::*;
#(
    parameter int REF_W  = 12,
    parameter int FRAC_W = 10,
    parameter int LAM_W  = 8,
    parameter int PERIOD = 100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [REF_W-1:0] ref_re,
    input  logic signed [REF_W-1:0] ref_im,
    input  logic [LAM_W-1:0]        lam,
    output logic [2:0]              sw_hi,
    output logic [2:0]              sw_lo,
    output logic                    ovm
);

    localparam int CNT_W = $clog2(PERIOD + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    typedef struct packed {
        sector_t          sec;
        logic [CNT_W-1:0] end_z;   // end of opening null slot
        logic [CNT_W-1:0] end_a;   // end of first active slot
        logic [CNT_W-1:0] end_b;   // end of second active slot
        logic             ovm;
    } per_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        per_t             per;
        legs_t            hi;
        logic             ovm;
    } st_t;

    st_t st_d, st_q;

    sector_t          sec_c;
    logic [REF_W:0]   mag_a_c, mag_b_c;
    logic [CNT_W-1:0] ta_c, tb_c, t0_c, t7_c;
    logic             ovm_c;
    vidx_t            idx_c;

    svm_sector_dec #(.REF_W(REF_W)) u_sec (
        .re_i    (ref_re),
        .im_i    (ref_im),
        .sec_o   (sec_c),
        .mag_a_o (mag_a_c),
        .mag_b_o (mag_b_c)
    );

    svm_dwell_calc #(
        .REF_W  (REF_W),
        .FRAC_W (FRAC_W),
        .LAM_W  (LAM_W),
        .PERIOD (PERIOD),
        .CNT_W  (CNT_W)
    ) u_dwell (
        .mag_a_i (mag_a_c),
        .mag_b_i (mag_b_c),
        .lam_i   (lam),
        .ta_o    (ta_c),
        .tb_o    (tb_c),
        .t0_o    (t0_c),
        .t7_o    (t7_c),
        .ovm_o   (ovm_c)
    );

    always_comb begin
        st_d  = st_q;
        idx_c = 3'd0;
        if (!en) begin
            st_d.cnt = LAST;
            st_d.hi  = 3'b000;
            st_d.ovm = 1'b0;
        end else begin
            if (st_q.cnt == LAST) begin
                st_d.cnt       = '0;
                st_d.per.sec   = sec_c;
                st_d.per.end_z = t0_c;
                st_d.per.end_a = t0_c + ta_c;
                st_d.per.end_b = t0_c + ta_c + tb_c;
                st_d.per.ovm   = ovm_c;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_d.cnt < st_d.per.end_z)      idx_c = 3'd0;
            else if (st_d.cnt < st_d.per.end_a) idx_c = st_d.per.sec;
            else if (st_d.cnt < st_d.per.end_b) idx_c = next_active(st_d.per.sec);
            else                                idx_c = 3'd7;
            st_d.hi  = vec_bits(idx_c);
            st_d.ovm = st_d.per.ovm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= LAST;
        end else begin
            st_q <= st_d;
        end
    end

    assign sw_hi = st_q.hi;
    assign sw_lo = ~st_q.hi;
    assign ovm   = st_q.ovm;

    // R2: a disabled cycle leaves the legs in the v0 state with no flag
    p_disable_v0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (sw_hi == 3'b000 && !ovm));

    // R4: decoded sector always lies in 1..6
    p_sector_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_c >= 3'd1 && sec_c <= 3'd6));

    // R5: once the closing null vector is reached it holds to the period end
    p_close_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && st_q.cnt != '0 && $past(sw_hi) == 3'b111)
        |-> sw_hi == 3'b111);

    // R7: all four dwell slots fill the period exactly
    p_slots_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ta_c) + int'(tb_c) + int'(t0_c) + int'(t7_c)) == PERIOD);

    // R8: overmodulation leaves no null time
    p_ovm_no_null_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovm_c |-> (t0_c == '0 && t7_c == '0));

    // R9: latched period data does not move inside a period
    p_hold_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && st_q.cnt != '0) |-> $stable(st_q.per));

    // R10: the cycle counter never passes the last slot of a period
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

endmodule

// File: tb/svm_fault_mod_tb.sv
module svm_fault_mod_tb;

    localparam int CLK_PERIOD = 10;
    localparam int P      = 100;
    localparam int RW     = 12;
    localparam int FW     = 10;
    localparam int LW     = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 en = 1'b0;
    logic signed [RW-1:0] ref_re = '0;
    logic signed [RW-1:0] ref_im = '0;
    logic [LW-1:0]        lam = 8'd128;
    logic [2:0]           sw_hi, sw_lo;
    logic                 ovm;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    string tag = "R1";

    // reference model state
    int m_cnt = P - 1;
    int m_sec = 1, m_t0 = 0, m_ta = 0, m_tb = 0, m_ov = 0;
    int m_hi = 0, m_ovo = 0;

    svm_fault_mod #(.REF_W(RW), .FRAC_W(FW), .LAM_W(LW), .PERIOD(P)) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .ref_re (ref_re),
        .ref_im (ref_im),
        .lam    (lam),
        .sw_hi  (sw_hi),
        .sw_lo  (sw_lo),
        .ovm    (ovm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // R5 vector table written from (leg A voltage, leg B voltage, neutral)
    function automatic int code_of(int v);
        case (v)
            0: return 0;
            1: return 4;
            2: return 6;
            3: return 2;
            4: return 3;
            5: return 1;
            6: return 5;
            default: return 7;
        endcase
    endfunction

    task automatic plan_period(int x, int y, int l);
        int k, a, b, n;
        // R4 sector choice
        if (x > 0 && y >= 0)      k = (x > y) ? 1 : 2;
        else if (x <= 0 && y > 0) k = 3;
        else if (x < 0 && y <= 0) k = (x < y) ? 4 : 5;
        else if (x >= 0 && y < 0) k = 6;
        else                      k = 1;
        // R6 raw magnitudes
        case (k)
            1: begin a = x - y; b = y;     end
            2: begin a = x;     b = y - x; end
            3: begin a = y;     b = -x;    end
            4: begin a = y - x; b = -y;    end
            5: begin a = -x;    b = x - y; end
            default: begin a = -y; b = x;  end
        endcase
        m_sec = k;
        if (a + b > (1 << FW)) begin   // R8
            m_ta = (a * P) / (a + b);
            m_tb = P - m_ta;
            m_ov = 1;
        end else begin
            m_ta = (a * P) / (1 << FW);
            m_tb = (b * P) / (1 << FW);
            m_ov = 0;
        end
        n = P - m_ta - m_tb;
        m_t0 = (n * l) / (1 << LW);    // R7
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = P - 1; m_hi = 0; m_ovo = 0;
        end else if (!en) begin
            m_cnt = P - 1; m_hi = 0; m_ovo = 0;
        end else begin
            int v;
            if (m_cnt == P - 1) begin
                plan_period(int'(ref_re), int'(ref_im), int'(lam));
                m_cnt = 0;
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (m_cnt < m_t0)                    v = 0;
            else if (m_cnt < m_t0 + m_ta)        v = m_sec;
            else if (m_cnt < m_t0 + m_ta + m_tb) v = (m_sec % 6) + 1;
            else                                 v = 7;
            m_hi  = code_of(v);
            m_ovo = m_ov;
        end
    end

    task automatic check(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            check(tag,  "sw_hi", int'(sw_hi), m_hi);
            check("R3", "sw_lo", int'(sw_lo), (~m_hi) & 7);
            check(tag,  "ovm",   int'(ovm),   m_ovo);
        end
    end

    task automatic run(string t, int x, int y, int l, int cycles);
        @(negedge clk);
        tag    = t;
        ref_re = RW'(x);
        ref_im = RW'(y);
        lam    = LW'(l);
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int gap;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", "sw_hi", int'(sw_hi), 0);
        check("R1", "sw_lo", int'(sw_lo), 7);
        check("R1", "ovm",   int'(ovm),   0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_on = 1'b1;
        tag = "R2";
        repeat (5) @(negedge clk);
        en = 1'b1;
        // R4 / R5 / R6: one interior point per sector
        run("R6", 300, 100, 128, 2*P);
        run("R6", 200, 400, 128, 2*P);
        run("R6", -150, 300, 128, 2*P);
        run("R6", -400, -100, 128, 2*P);
        run("R5", -100, -300, 128, 2*P);
        run("R5", 250, -350, 128, 2*P);
        // R4 border points and origin
        run("R4", 0, 0, 128, 2*P);
        run("R4", 300, 300, 128, 2*P);
        run("R4", 0, -200, 128, 2*P);
        run("R4", -200, 0, 128, 2*P);
        run("R4", 0, 200, 128, 2*P);
        run("R4", -250, -250, 128, 2*P);
        // R7 split fraction sweep
        run("R7", 200, 100, 0, 2*P);
        run("R7", 200, 100, 255, 2*P);
        run("R7", 200, 100, 64, 2*P);
        // R8 scaled path
        run("R8", 1000, 900, 128, 2*P);
        run("R8", 1023, -1023, 128, 2*P);
        run("R8", -1500, -1500, 128, 2*P);
        run("R8", 2047, 0, 128, 2*P);
        run("R8", -2048, 2047, 77, 2*P);
        // R9 mid-period change of every sampled input
        run("R9", 300, 100, 128, P + 10);
        run("R9", -600, 500, 30, 2*P);
        // R2 disable mid-period and restart
        run("R2", 100, -400, 200, 37);
        en = 1'b0;
        repeat (4) @(negedge clk);
        check("R2", "sw_hi disabled", int'(sw_hi), 0);
        check("R2", "ovm disabled",   int'(ovm),   0);
        en = 1'b1;
        run("R2", 100, -400, 200, 2*P);
        // R10 period length measured at the ports
        run("R10", 300, 100, 128, 2*P);
        while (!(sw_hi == 3'b000)) @(negedge clk);
        while (sw_hi == 3'b000) @(negedge clk);
        while (!(sw_hi == 3'b000)) @(negedge clk);
        gap = 0;
        while (sw_hi == 3'b000) begin gap++; @(negedge clk); end
        while (!(sw_hi == 3'b000)) begin gap++; @(negedge clk); end
        check("R10", "period cycles", gap, P);
        chk_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule